// File: doc/BRIEF.md
# Angle Offset and Analog Scaling Unit

This block sits between an 8-bit absolute angle converter and the two consumers of its result: a serial readout path and an analog output DAC. On every sample strobe it takes the raw angle and the raw fault flags. It reverses the counting direction when asked and adds a programmable zero offset modulo 256. The corrected position goes out as a byte. The same position is mapped onto a 10-bit DAC code for the selected full-scale angle and output voltage window. The two fault flags are gated through an error mask into an active-low error line.

The configuration arrives as three redundant 14-bit parameter sets. Each field (offset, mode, mask) is the bitwise XOR of the same field across the three sets. A field that was programmed in one set can therefore be changed later by programming another set. A small controller with two states, ST_EMPTY and ST_LIVE, owns the output registers. ST_EMPTY holds the reset values until the first strobe. On that strobe it loads the outputs and takes the transition T_FIRST to ST_LIVE. ST_LIVE reloads the outputs on every later strobe (T_RELOAD, staying in ST_LIVE) and holds them on every other cycle (T_HOLD). Only reset returns the controller to ST_EMPTY.

Top module: `aosu_top`

## Requirements
- R1: Each configuration set is laid out as bits 7:0 offset, bits 11:8 mode, bits 13:12 error mask. The effective value of each field is the XOR of that field over the three sets.
- R2: Effective mode bit 2 = 0 keeps the raw angle. Mode bit 2 = 1 replaces it with (256 - raw) mod 256. This reversal is applied before the offset.
- R3: The position byte is the direction-corrected angle plus the effective offset, modulo 256.
- R4: Effective mode bits 1:0 select the full-scale angle, which ends at position TOP: 00 = 360 deg (TOP 255), 01 = 270 deg (TOP 191), 10 = 180 deg (TOP 127), 11 = 90 deg (TOP 63). With mode bit 3 = 0, the DAC code is floor(pos * 1023 / TOP). Position 0 gives code 0.
- R5: Positions above TOP saturate at the code for TOP and do not wrap. That code is 1023 with the full-rail window and 921 with the narrowed window.
- R6: With effective mode bit 3 = 1, the DAC code is 102 + floor(s * 819 / 1023), where s is the R4 code. The code therefore stays within 102 to 921.
- R7: Mask bit 0 enables the loss-of-magnet flag and mask bit 1 enables the overspeed flag. The error output is low when an enabled flag is high at the strobe, and high otherwise. Mask 00 reports nothing.
- R8: All outputs are registered. They change only at a clock edge where the sample strobe is high, and they take the values computed from that cycle's inputs. At every other edge they hold.
- R9: After reset, the position and the DAC code read 0 and the error output reads high. These values hold until the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | New angle sample is valid this cycle |
| raw_angle | input | 8 | Absolute angle from the converter |
| loss_flag | input | 1 | Raw loss-of-magnet indication |
| speed_flag | input | 1 | Raw overspeed indication |
| cfg_set0 | input | 14 | First redundant parameter set |
| cfg_set1 | input | 14 | Second redundant parameter set |
| cfg_set2 | input | 14 | Third redundant parameter set |
| pos_word | output | 8 | Corrected position for serial readout |
| dac_code | output | 10 | Code for the analog output DAC |
| err_n | output | 1 | Active-low masked error |

## Verification
The assertions assume that the raw angle, the fault flags and all three parameter sets are settled and valid in any cycle where sample_stb is high. They make no assumption about those inputs in other cycles. The stimulus drives every input half a cycle before the sampling edge and pulses the strobe for exactly one cycle. It also changes inputs while the strobe is low, so that the hold behaviour is exercised. Configurations are chosen so that each field is set through different sets, including cases where two sets cancel each other.

// File: rtl/aosu_pkg.sv
package aosu_pkg;

    localparam int ANG_W = 8;
    localparam int OFS_W = ANG_W;
    localparam int MODE_W = 4;
    localparam int MASK_W = 2;
    localparam int CFG_W = OFS_W + MODE_W + MASK_W;
    localparam int NUM_RANGES = 4;

    typedef enum logic [1:0] {
        RNG_360 = 2'b00,
        RNG_270 = 2'b01,
        RNG_180 = 2'b10,
        RNG_90  = 2'b11
    } range_e;

    typedef struct packed {
        logic   window;
        logic   ccw;
        range_e range;
    } mode_t;

    typedef struct packed {
        logic [MASK_W-1:0] emask;
        mode_t             mode;
        logic [OFS_W-1:0]  offset;
    } cfg_set_t;

    // Last position inside the full-scale angle for a range code
    function automatic int top_count(input int code);
        case (code)
            0:       return (1 << ANG_W) - 1;
            1:       return (3 << (ANG_W - 2)) - 1;
            2:       return (1 << (ANG_W - 1)) - 1;
            default: return (1 << (ANG_W - 2)) - 1;
        endcase
    endfunction

endpackage

// File: rtl/aosu_cfg_merge.sv
module aosu_cfg_merge
    import aosu_pkg::*;
#(
    parameter int NSETS = 3
) (
    input  cfg_set_t sets_i [NSETS],
    output cfg_set_t merged_o
);

    always_comb begin
        merged_o = '0;
        for (int i = 0; i < NSETS; i++) begin
            merged_o = merged_o ^ sets_i[i];
        end
    end

endmodule

// File: rtl/aosu_pos_xform.sv
module aosu_pos_xform
    import aosu_pkg::*;
(
    input  logic [ANG_W-1:0] raw_i,
    input  logic             ccw_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [ANG_W-1:0] pos_o
);

    logic [ANG_W-1:0] dir_angle;

    // Reverse first, then shift the zero point
    always_comb begin
        dir_angle = ccw_i ? (~raw_i + 1'b1) : raw_i;
        pos_o     = dir_angle + offset_i;
    end

endmodule

// File: rtl/aosu_span_map.sv
module aosu_span_map
    import aosu_pkg::*;
#(
    parameter int DAC_W    = 10,
    parameter int WIN_LO   = 102,
    parameter int WIN_SPAN = 819
) (
    input  logic [ANG_W-1:0] pos_i,
    input  mode_t            mode_i,
    output logic [DAC_W-1:0] code_o
);

    localparam int FULL = (1 << DAC_W) - 1;

    logic [31:0] quot [NUM_RANGES];

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
        localparam int TOP = top_count(g);
        logic [31:0] clamped;
        always_comb begin
            clamped = (32'(pos_i) > 32'(TOP)) ? 32'(TOP) : 32'(pos_i);
        end
        assign quot[g] = (clamped * 32'(FULL)) / 32'(TOP);
    end

    logic [31:0] scaled;
    logic [31:0] mapped;

    always_comb begin
        scaled = quot[mode_i.range];
        if (mode_i.window) begin
            mapped = 32'(WIN_LO) + (scaled * 32'(WIN_SPAN)) / 32'(FULL);
        end else begin
            mapped = scaled;
        end
        code_o = mapped[DAC_W-1:0];
    end

endmodule

// File: rtl/aosu_err_gate.sv
module aosu_err_gate
    import aosu_pkg::*;
(
    input  logic [MASK_W-1:0] emask_i,
    input  logic              loss_i,
    input  logic              speed_i,
    output logic              fault_o
);

    always_comb begin
        fault_o = (emask_i[0] & loss_i) | (emask_i[1] & speed_i);
    end

endmodule

// File: rtl/aosu_top.sv
module aosu_top
    import aosu_pkg::*;
#(
    parameter int DAC_W    = 10,
    parameter int WIN_LO   = 102,
    parameter int WIN_SPAN = 819
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [ANG_W-1:0] raw_angle,
    input  logic             loss_flag,
    input  logic             speed_flag,
    input  logic [CFG_W-1:0] cfg_set0,
    input  logic [CFG_W-1:0] cfg_set1,
    input  logic [CFG_W-1:0] cfg_set2,
    output logic [ANG_W-1:0] pos_word,
    output logic [DAC_W-1:0] dac_code,
    output logic             err_n
);

    localparam int NSETS   = 3;
    localparam int FULL    = (1 << DAC_W) - 1;
    localparam int TOP_90  = top_count(3);
    localparam int WIN_HI  = WIN_LO + WIN_SPAN;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_LIVE  = 1'b1
    } state_e;

    state_e state_q, state_d;

    cfg_set_t         sets [NSETS];
    cfg_set_t         cfg;
    logic [ANG_W-1:0] pos_next;
    logic [DAC_W-1:0] code_next;
    logic             fault_next;

    assign sets[0] = cfg_set_t'(cfg_set0);
    assign sets[1] = cfg_set_t'(cfg_set1);
    assign sets[2] = cfg_set_t'(cfg_set2);

    aosu_cfg_merge #(.NSETS(NSETS)) u_merge (
        .sets_i   (sets),
        .merged_o (cfg)
    );

    aosu_pos_xform u_xform (
        .raw_i    (raw_angle),
        .ccw_i    (cfg.mode.ccw),
        .offset_i (cfg.offset),
        .pos_o    (pos_next)
    );

    aosu_span_map #(
        .DAC_W    (DAC_W),
        .WIN_LO   (WIN_LO),
        .WIN_SPAN (WIN_SPAN)
    ) u_span (
        .pos_i  (pos_next),
        .mode_i (cfg.mode),
        .code_o (code_next)
    );

    aosu_err_gate u_err (
        .emask_i (cfg.emask),
        .loss_i  (loss_flag),
        .speed_i (speed_flag),
        .fault_o (fault_next)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (sample_stb) state_d = ST_LIVE;   // T_FIRST
            ST_LIVE:  state_d = ST_LIVE;                   // T_RELOAD / T_HOLD
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_word <= '0;
            dac_code <= '0;
            err_n    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_EMPTY, ST_LIVE: begin
                    if (sample_stb) begin
                        pos_word <= pos_next;
                        dac_code <= code_next;
                        err_n    <= ~fault_next;
                    end
                end
            endcase
        end
    end

    // R8: no strobe, no change
    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ($stable(pos_word) && $stable(dac_code) && $stable(err_n)));

    // R9: values while no sample has been taken
    a_r9_empty_values: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (pos_word == '0 && dac_code == '0 && err_n));

    // R7: empty mask never reports
    a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && cfg.emask == '0) |=> err_n);

    // R2, R3: neutral direction and zero offset pass the raw angle through
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !cfg.mode.ccw && cfg.offset == '0) |=> (pos_word == $past(raw_angle)));

    // R6: narrowed window bounds
    a_r6_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && cfg.mode.window) |=>
            (32'(dac_code) >= 32'(WIN_LO) && 32'(dac_code) <= 32'(WIN_HI)));

    // R5: beyond the 90 degree end the full-rail code saturates
    a_r5_saturate_90: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !cfg.mode.window && cfg.mode.range == RNG_90 &&
         32'(pos_next) >= 32'(TOP_90)) |=> (32'(dac_code) == 32'(FULL)));

endmodule

// File: tb/sim_aosu_top.sv
module sim_aosu_top;
    import aosu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [7:0]  raw_angle = '0;
    logic        loss_flag = 1'b0;
    logic        speed_flag = 1'b0;
    logic [13:0] cfg_set0 = '0;
    logic [13:0] cfg_set1 = '0;
    logic [13:0] cfg_set2 = '0;
    logic [7:0]  pos_word;
    logic [9:0]  dac_code;
    logic        err_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    aosu_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .raw_angle  (raw_angle),
        .loss_flag  (loss_flag),
        .speed_flag (speed_flag),
        .cfg_set0   (cfg_set0),
        .cfg_set1   (cfg_set1),
        .cfg_set2   (cfg_set2),
        .pos_word   (pos_word),
        .dac_code   (dac_code),
        .err_n      (err_n)
    );

    // {raw, set0, set1, set2, loss, speed, expected pos, expected err_n}
    // each set = {mask[1:0], mode[3:0], offset[7:0]}
    localparam int NVEC = 16;
    localparam logic [60:0] VEC [NVEC] = '{
        {8'h10, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b1,1'b1, 8'h10, 1'b1},
        {8'h10, {2'b00,4'b0000,8'h05}, {2'b00,4'b0000,8'h03}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h16, 1'b1},
        {8'h10, {2'b00,4'b0100,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'hF0, 1'b1},
        {8'h10, {2'b00,4'b0100,8'h20}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h10, 1'b1},
        {8'hF0, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h20}, 1'b0,1'b0, 8'h10, 1'b1},
        {8'h40, {2'b00,4'b0000,8'h00}, {2'b01,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b1,1'b0, 8'h40, 1'b0},
        {8'h40, {2'b00,4'b0000,8'h00}, {2'b01,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b1, 8'h40, 1'b1},
        {8'h40, {2'b11,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, {2'b01,4'b0000,8'h00}, 1'b0,1'b1, 8'h40, 1'b0},
        {8'h40, {2'b11,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h40, 1'b1},
        {8'hC0, {2'b00,4'b0001,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'hC0, 1'b1},
        {8'h20, {2'b00,4'b0000,8'h00}, {2'b00,4'b0011,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h20, 1'b1},
        {8'h00, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b1000,8'h00}, 1'b0,1'b0, 8'h00, 1'b1},
        {8'h7F, {2'b00,4'b1010,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h7F, 1'b1},
        {8'h33, {2'b00,4'b0100,8'h00}, {2'b00,4'b0100,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h33, 1'b1},
        {8'hFF, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'hFF, 1'b1},
        {8'h01, {2'b00,4'b0100,8'h01}, {2'b00,4'b0000,8'h00}, {2'b00,4'b0000,8'h00}, 1'b0,1'b0, 8'h00, 1'b1}
    };

    // DAC expectation from R4, R5, R6
    function automatic int dac_model(input int pos, input logic [3:0] mode);
        int top;
        int c;
        int s;
        case (mode[1:0])
            2'b00:   top = 255;
            2'b01:   top = 191;
            2'b10:   top = 127;
            default: top = 63;
        endcase
        c = (pos > top) ? top : pos;
        s = (c * 1023) / top;
        if (mode[3]) s = 102 + (s * 819) / 1023;
        return s;
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic strobe_sample();
        @(negedge clk);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9 pos after reset", int'(pos_word), 0);
        check("R9 dac after reset", int'(dac_code), 0);
        check("R9 err_n after reset", int'(err_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        raw_angle = 8'h55;
        loss_flag = 1'b1;
        cfg_set0 = {2'b01, 4'b0000, 8'h00};
        repeat (2) @(negedge clk);
        check("R9 pos holds before first strobe", int'(pos_word), 0);
        check("R9 err_n holds before first strobe", int'(err_n), 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] s0;
            logic [13:0] s1;
            logic [13:0] s2;
            logic [3:0]  mode_eff;
            s0 = VEC[i][52:39];
            s1 = VEC[i][38:25];
            s2 = VEC[i][24:11];
            mode_eff = s0[11:8] ^ s1[11:8] ^ s2[11:8];
            @(negedge clk);
            raw_angle  = VEC[i][60:53];
            cfg_set0   = s0;
            cfg_set1   = s1;
            cfg_set2   = s2;
            loss_flag  = VEC[i][10];
            speed_flag = VEC[i][9];
            strobe_sample();
            // R1 R2 R3: merged direction and offset
            check($sformatf("R3 R1 R2 pos vector %0d", i), int'(pos_word), int'(VEC[i][8:1]));
            // R7: masked error
            check($sformatf("R7 err_n vector %0d", i), int'(err_n), int'(VEC[i][0]));
            // R4 R5 R6: scaling
            check($sformatf("R4 R5 R6 dac vector %0d", i), int'(dac_code),
                  dac_model(int'(VEC[i][8:1]), mode_eff));
        end

        // R4: exact end points
        @(negedge clk);
        cfg_set0 = {2'b00, 4'b0010, 8'h00}; cfg_set1 = '0; cfg_set2 = '0;
        raw_angle = 8'd127; loss_flag = 1'b0; speed_flag = 1'b0;
        strobe_sample();
        check("R4 180 deg end code", int'(dac_code), 1023);
        @(negedge clk);
        raw_angle = 8'd64;
        strobe_sample();
        check("R4 180 deg mid code", int'(dac_code), 515);
        @(negedge clk);
        raw_angle = 8'd200;
        strobe_sample();
        check("R5 180 deg beyond end saturates", int'(dac_code), 1023);
        @(negedge clk);
        cfg_set0 = {2'b00, 4'b1011, 8'h00};
        raw_angle = 8'd250;
        strobe_sample();
        check("R5 R6 90 deg window saturates", int'(dac_code), 921);
        @(negedge clk);
        cfg_set0 = {2'b00, 4'b1000, 8'h00};
        raw_angle = 8'd128;
        strobe_sample();
        check("R6 window 360 deg mid", int'(dac_code), 102 + (((128 * 1023) / 255) * 819) / 1023);

        // R8: inputs change without a strobe
        @(negedge clk);
        raw_angle = 8'h0A; cfg_set0 = {2'b11, 4'b0100, 8'h11};
        loss_flag = 1'b1; speed_flag = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 pos holds without strobe", int'(pos_word), 128);
        check("R8 err_n holds without strobe", int'(err_n), 1);
        check("R8 dac holds without strobe", int'(dac_code), 102 + (((128 * 1023) / 255) * 819) / 1023);
        strobe_sample();
        check("R8 pos loads on strobe", int'(pos_word), 8'h07);
        check("R8 err_n loads on strobe", int'(err_n), 0);

        // R9: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 pos after second reset", int'(pos_word), 0);
        check("R9 err_n after second reset", int'(err_n), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule